// File: doc/BRIEF.md
# Processor Interrupt Presentation Unit with Inter-Processor Interrupt

This block sits beside one processor and decides whether that processor is interrupted. It keeps four pieces of state: the processor's current priority threshold, the priority of a software-requested inter-processor interrupt (IPI), and a single pending slot made of a source number and that source's priority. Priorities are 8 bits wide and a numerically smaller value is more urgent. A slot priority of 0xFF with source number 0 means the slot is empty. The IPI is not kept apart from external interrupts: it occupies the same pending slot under the reserved source number 2.

A source controller offers interrupts on one port. The processor side issues four operations on a second port: accept, write threshold, write IPI priority and end-of-interrupt. Each cycle the decoder assigns a single transition kind. The kinds are: K_IDLE (nothing), K_OFFER (source offer), K_ACCEPT (accept with a pending slot), K_ACCEPT_EMPTY (accept with an empty slot), K_CPPR_SAME (threshold write equal to the current value), K_CPPR_UP (threshold write to a smaller value), K_CPPR_DOWN (threshold write to a larger value), K_MFRR (IPI priority write) and K_EOI (end-of-interrupt). Every transition completes in one clock cycle.

Source numbers that leave the slot without being delivered are returned to the source side as reject pulses. A resend pulse tells the source side to offer again any interrupt it was refused earlier. The resend pulse is driven from a stored need-resend flag.

Top module: `irq_presenter`

## Requirements
- R1: A synchronous reset loads threshold 0x00, IPI priority 0xFF, slot priority 0xFF, slot source 0 and a cleared need-resend flag. After reset `irq_out` is 0 and an accept returns 0x00000000.
- R2: `irq_out` is 1 exactly when the slot source is nonzero and the slot priority is numerically less than the threshold. It follows the registered state with no further delay.
- R3: An accept (op_code 0) pulses `acc_valid` for one cycle after the operation, with `acc_word` = {threshold in bits 31:24, slot source in bits 23:0}, both taken from before the operation. If the slot was occupied, the threshold takes the slot priority and the slot empties. Otherwise nothing changes.
- R4: An IPI priority write (op_code 2, value in op_data[7:0]) always stores the value. If the value is less than the threshold, the slot becomes source 2 at that priority. If, in addition, the value is less than or equal to the old slot priority, the old slot source is rejected on the op reject port.
- R5: An IPI priority write whose value is greater than both the old IPI priority and the threshold emits the need-resend flag as a `resend_req` pulse and clears the flag.
- R6: A threshold write (op_code 1, value in op_data[7:0]) equal to the current threshold changes nothing. A smaller value sets the threshold. If that new value is also less than or equal to the slot priority, the slot source is rejected and the slot empties.
- R7: A threshold write with a larger value takes the lowering path. The threshold is set to the new value. If the IPI priority is less than the new threshold and less than or equal to the slot priority, the slot becomes source 2 at the IPI priority. The need-resend flag is emitted as `resend_req` and cleared.
- R8: An end-of-interrupt (op_code 3) applies op_data[31:24] as a new threshold through the lowering path. If op_data[23:0] names a source other than 0 or 2 and `eoi_src_active` is 1, that source is emitted on the op reject port.
- R9: A source offer is taken when no operation is present in the same cycle and its source is nonzero. If its priority is less than both the threshold and the slot priority, it replaces the slot and the displaced source is rejected on the offer reject port. Otherwise the offered source itself is rejected there and the need-resend flag is set.
- R10: An offer that arrives in the same cycle as an operation is refused. Its source is rejected on the offer reject port, the need-resend flag is set, and the operation proceeds unchanged.
- R11: Reject and resend outputs are single-cycle pulses registered one cycle after their cause. A reject whose source would be 0 or the IPI number 2 is never emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| op_valid | input | 1 | Processor operation present |
| op_code | input | 2 | 0 accept, 1 write threshold, 2 write IPI priority, 3 end-of-interrupt |
| op_data | input | 32 | Operation operand |
| eoi_src_active | input | 1 | Source side reports the completed source as still asserted |
| irq_out | output | 1 | Interrupt request to the processor |
| acc_valid | output | 1 | Accept result valid pulse |
| acc_word | output | 32 | Accept result {threshold, source} |
| op_rej_valid | output | 1 | Reject pulse caused by an operation |
| op_rej_src | output | 24 | Source number rejected by an operation |
| ofr_rej_valid | output | 1 | Reject pulse caused by an offer |
| ofr_rej_src | output | 24 | Source number rejected by an offer |
| resend_req | output | 1 | Request for the source side to re-offer |

## Verification
A corrupted threshold or slot shows on `irq_out` in the cycle after the faulty update. It also shows in the next accept word, and in whether a later threshold write or IPI write rejects a source. A lost or stuck need-resend flag stays hidden until the next lowering path or rising IPI write, where `resend_req` is missing or extra. The sequences therefore set the flag on purpose and then clear it several steps later. A wrong suppression of the IPI number shows at once as a reject pulse carrying source 2, or as the absence of an expected pulse one cycle after its cause.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [3:0] {
        K_IDLE,
        K_OFFER,
        K_ACCEPT,
        K_ACCEPT_EMPTY,
        K_CPPR_SAME,
        K_CPPR_UP,
        K_CPPR_DOWN,
        K_MFRR,
        K_EOI
    } kind_t;

    localparam logic [1:0] OPC_ACCEPT = 2'd0;
    localparam logic [1:0] OPC_THRESH = 2'd1;
    localparam logic [1:0] OPC_IPIPRI = 2'd2;
    localparam logic [1:0] OPC_EOI    = 2'd3;

endpackage

// File: rtl/ipc_decode.sv
module ipc_decode
    import ipc_pkg::*;
#(
    parameter int PRI_W = 8,
    parameter int SRC_W = 24
) (
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [PRI_W-1:0] op_pri,
    input  logic             offer_valid,
    input  logic [SRC_W-1:0] offer_src,
    input  logic [PRI_W-1:0] cur_thresh,
    input  logic             slot_full,
    output kind_t            kind,
    output logic             offer_bounce
);

    always_comb begin
        kind = K_IDLE;
        if (op_valid) begin
            unique case (op_code)
                OPC_ACCEPT: kind = slot_full ? K_ACCEPT : K_ACCEPT_EMPTY;
                OPC_THRESH: begin
                    if (op_pri == cur_thresh)
                        kind = K_CPPR_SAME;
                    else if (op_pri > cur_thresh)
                        kind = K_CPPR_DOWN;
                    else
                        kind = K_CPPR_UP;
                end
                OPC_IPIPRI: kind = K_MFRR;
                OPC_EOI:    kind = K_EOI;
            endcase
        end else if (offer_valid && (offer_src != '0)) begin
            kind = K_OFFER;
        end
    end

    assign offer_bounce = op_valid && offer_valid && (offer_src != '0);

endmodule

// File: rtl/ipc_op_engine.sv
module ipc_op_engine
    import ipc_pkg::*;
#(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  kind_t                    kind,
    input  logic [PRI_W+SRC_W-1:0]   op_data,
    input  logic                     eoi_src_active,
    input  logic [PRI_W-1:0]         cur_thresh,
    input  logic [PRI_W-1:0]         cur_ipi,
    input  logic [PRI_W-1:0]         cur_pend,
    input  logic [SRC_W-1:0]         cur_src,
    input  logic                     cur_need,
    output logic [PRI_W-1:0]         nx_thresh,
    output logic [PRI_W-1:0]         nx_ipi,
    output logic [PRI_W-1:0]         nx_pend,
    output logic [SRC_W-1:0]         nx_src,
    output logic                     clr_need,
    output logic                     fire_resend,
    output logic                     fire_rej,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     fire_acc,
    output logic [PRI_W+SRC_W-1:0]   acc_word
);

    localparam int WORD_W = PRI_W + SRC_W;
    localparam logic [PRI_W-1:0] EMPTY_PRI = '1;
    localparam logic [SRC_W-1:0] IPI_NUM   = SRC_W'(IPI_SRC);

    logic [PRI_W-1:0] new_pri;
    logic [PRI_W-1:0] eoi_pri;
    logic [SRC_W-1:0] eoi_src;
    logic [PRI_W-1:0] down_val;
    logic             down_ipi;

    assign new_pri  = op_data[PRI_W-1:0];
    assign eoi_pri  = op_data[WORD_W-1 -: PRI_W];
    assign eoi_src  = op_data[SRC_W-1:0];
    assign down_val = (kind == K_EOI) ? eoi_pri : new_pri;
    assign down_ipi = (cur_ipi < down_val) && (cur_ipi <= cur_pend);

    function automatic logic real_src(input logic [SRC_W-1:0] s);
        return (s != '0) && (s != IPI_NUM);
    endfunction

    always_comb begin
        nx_thresh   = cur_thresh;
        nx_ipi      = cur_ipi;
        nx_pend     = cur_pend;
        nx_src      = cur_src;
        clr_need    = 1'b0;
        fire_resend = 1'b0;
        fire_rej    = 1'b0;
        rej_src     = '0;
        fire_acc    = 1'b0;
        acc_word    = {cur_thresh, cur_src};
        unique case (kind)
            K_ACCEPT: begin
                fire_acc  = 1'b1;
                nx_thresh = cur_pend;
                nx_pend   = EMPTY_PRI;
                nx_src    = '0;
            end
            K_ACCEPT_EMPTY: begin
                fire_acc = 1'b1;
            end
            K_CPPR_UP: begin
                nx_thresh = new_pri;
                if (new_pri <= cur_pend) begin
                    fire_rej = real_src(cur_src);
                    rej_src  = cur_src;
                    nx_pend  = EMPTY_PRI;
                    nx_src   = '0;
                end
            end
            K_CPPR_DOWN, K_EOI: begin
                nx_thresh   = down_val;
                if (down_ipi) begin
                    nx_pend = cur_ipi;
                    nx_src  = IPI_NUM;
                end
                fire_resend = cur_need;
                clr_need    = 1'b1;
                if (kind == K_EOI && eoi_src_active && real_src(eoi_src)) begin
                    fire_rej = 1'b1;
                    rej_src  = eoi_src;
                end
            end
            K_MFRR: begin
                nx_ipi = new_pri;
                if (new_pri < cur_thresh) begin
                    if (new_pri <= cur_pend) begin
                        fire_rej = real_src(cur_src);
                        rej_src  = cur_src;
                    end
                    nx_pend = new_pri;
                    nx_src  = IPI_NUM;
                end
                if ((new_pri > cur_ipi) && (new_pri > cur_thresh)) begin
                    fire_resend = cur_need;
                    clr_need    = 1'b1;
                end
            end
            K_IDLE, K_OFFER, K_CPPR_SAME: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/ipc_offer_engine.sv
module ipc_offer_engine #(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic             take_offer,
    input  logic             bounce,
    input  logic [SRC_W-1:0] offer_src,
    input  logic [PRI_W-1:0] offer_pri,
    input  logic [PRI_W-1:0] cur_thresh,
    input  logic [PRI_W-1:0] cur_pend,
    input  logic [SRC_W-1:0] cur_src,
    output logic             win,
    output logic             set_need,
    output logic             fire_rej,
    output logic [SRC_W-1:0] rej_src
);

    localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

    logic better;
    assign better = (offer_pri < cur_thresh) && (offer_pri < cur_pend);

    always_comb begin
        win      = 1'b0;
        set_need = 1'b0;
        fire_rej = 1'b0;
        rej_src  = '0;
        if (bounce) begin
            set_need = 1'b1;
            fire_rej = 1'b1;
            rej_src  = offer_src;
        end else if (take_offer) begin
            if (better) begin
                win      = 1'b1;
                fire_rej = (cur_src != '0) && (cur_src != IPI_NUM);
                rej_src  = cur_src;
            end else begin
                set_need = 1'b1;
                fire_rej = 1'b1;
                rej_src  = offer_src;
            end
        end
    end

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
    import ipc_pkg::*;
#(
    parameter int PRI_W   = 8,
    parameter int SRC_W   = 24,
    parameter int IPI_SRC = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   offer_valid,
    input  logic [SRC_W-1:0]       offer_src,
    input  logic [PRI_W-1:0]       offer_pri,
    input  logic                   op_valid,
    input  logic [1:0]             op_code,
    input  logic [PRI_W+SRC_W-1:0] op_data,
    input  logic                   eoi_src_active,
    output logic                   irq_out,
    output logic                   acc_valid,
    output logic [PRI_W+SRC_W-1:0] acc_word,
    output logic                   op_rej_valid,
    output logic [SRC_W-1:0]       op_rej_src,
    output logic                   ofr_rej_valid,
    output logic [SRC_W-1:0]       ofr_rej_src,
    output logic                   resend_req
);

    localparam int WORD_W = PRI_W + SRC_W;
    localparam logic [PRI_W-1:0] EMPTY_PRI = '1;
    localparam logic [SRC_W-1:0] IPI_NUM   = SRC_W'(IPI_SRC);

    logic [PRI_W-1:0] thresh_q, ipi_q, pend_q;
    logic [SRC_W-1:0] src_q;
    logic             need_q;

    kind_t            kind;
    logic             bounce;

    logic [PRI_W-1:0] e_thresh, e_ipi, e_pend;
    logic [SRC_W-1:0] e_src;
    logic             e_clr_need, e_resend, e_rej, e_acc;
    logic [SRC_W-1:0] e_rej_src;
    logic [WORD_W-1:0] e_acc_word;

    logic             o_win, o_set_need, o_rej;
    logic [SRC_W-1:0] o_rej_src;

    logic [PRI_W-1:0] n_pend;
    logic [SRC_W-1:0] n_src;
    logic             n_need;

    ipc_decode #(.PRI_W(PRI_W), .SRC_W(SRC_W)) u_decode (
        .op_valid     (op_valid),
        .op_code      (op_code),
        .op_pri       (op_data[PRI_W-1:0]),
        .offer_valid  (offer_valid),
        .offer_src    (offer_src),
        .cur_thresh   (thresh_q),
        .slot_full    (src_q != '0),
        .kind         (kind),
        .offer_bounce (bounce)
    );

    ipc_op_engine #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_op (
        .kind           (kind),
        .op_data        (op_data),
        .eoi_src_active (eoi_src_active),
        .cur_thresh     (thresh_q),
        .cur_ipi        (ipi_q),
        .cur_pend       (pend_q),
        .cur_src        (src_q),
        .cur_need       (need_q),
        .nx_thresh      (e_thresh),
        .nx_ipi         (e_ipi),
        .nx_pend        (e_pend),
        .nx_src         (e_src),
        .clr_need       (e_clr_need),
        .fire_resend    (e_resend),
        .fire_rej       (e_rej),
        .rej_src        (e_rej_src),
        .fire_acc       (e_acc),
        .acc_word       (e_acc_word)
    );

    ipc_offer_engine #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_offer (
        .take_offer (kind == K_OFFER),
        .bounce     (bounce),
        .offer_src  (offer_src),
        .offer_pri  (offer_pri),
        .cur_thresh (thresh_q),
        .cur_pend   (pend_q),
        .cur_src    (src_q),
        .win        (o_win),
        .set_need   (o_set_need),
        .fire_rej   (o_rej),
        .rej_src    (o_rej_src)
    );

    always_comb begin
        n_pend = o_win ? offer_pri : e_pend;
        n_src  = o_win ? offer_src : e_src;
        n_need = (need_q && !e_clr_need) || o_set_need;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh_q <= '0;
            ipi_q    <= EMPTY_PRI;
            pend_q   <= EMPTY_PRI;
            src_q    <= '0;
            need_q   <= 1'b0;
        end else begin
            thresh_q <= e_thresh;
            ipi_q    <= e_ipi;
            pend_q   <= n_pend;
            src_q    <= n_src;
            need_q   <= n_need;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_valid     <= 1'b0;
            acc_word      <= '0;
            op_rej_valid  <= 1'b0;
            op_rej_src    <= '0;
            ofr_rej_valid <= 1'b0;
            ofr_rej_src   <= '0;
            resend_req    <= 1'b0;
        end else begin
            acc_valid     <= e_acc;
            acc_word      <= e_acc ? e_acc_word : '0;
            op_rej_valid  <= e_rej;
            op_rej_src    <= e_rej ? e_rej_src : '0;
            ofr_rej_valid <= o_rej;
            ofr_rej_src   <= o_rej ? o_rej_src : '0;
            resend_req    <= e_resend;
        end
    end

    assign irq_out = (src_q != '0) && (pend_q < thresh_q);

    // R2: an occupied slot never carries the empty priority, and vice versa
    a_r2_slot_pair: assert property (@(posedge clk) disable iff (rst)
        (src_q == '0) == (pend_q == EMPTY_PRI));

    // R3: an accept of an occupied slot moves its priority into the threshold
    a_r3_accept_take: assert property (@(posedge clk) disable iff (rst)
        (kind == K_ACCEPT) |=> (thresh_q == $past(pend_q)) && (src_q == '0));

    // R6: an equal threshold write leaves every register unchanged
    a_r6_same_stable: assert property (@(posedge clk) disable iff (rst)
        (kind == K_CPPR_SAME && !offer_valid) |=>
            $stable(thresh_q) && $stable(pend_q) && $stable(src_q) && $stable(need_q));

    // R4: a more urgent IPI write leaves the IPI in the slot
    a_r4_ipi_in_slot: assert property (@(posedge clk) disable iff (rst)
        (kind == K_MFRR && op_data[PRI_W-1:0] < thresh_q) |=>
            (src_q == IPI_NUM) && (pend_q == ipi_q));

    // R11: operation rejects never carry 0 or the IPI number
    a_r11_op_rej_real: assert property (@(posedge clk) disable iff (rst)
        op_rej_valid |-> (op_rej_src != '0) && (op_rej_src != IPI_NUM));

    // R11: offer rejects never carry source 0
    a_r11_ofr_rej_real: assert property (@(posedge clk) disable iff (rst)
        ofr_rej_valid |-> (ofr_rej_src != '0));

    // R10: a colliding offer is always returned
    a_r10_bounce_return: assert property (@(posedge clk) disable iff (rst)
        (op_valid && offer_valid && offer_src != '0) |=>
            ofr_rej_valid && (ofr_rej_src == $past(offer_src)));

endmodule

// File: tb/test_irq_presenter.sv
module test_irq_presenter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        offer_valid = 1'b0;
    logic [23:0] offer_src = '0;
    logic [7:0]  offer_pri = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        eoi_src_active = 1'b0;
    logic        irq_out, acc_valid, op_rej_valid, ofr_rej_valid, resend_req;
    logic [31:0] acc_word;
    logic [23:0] op_rej_src, ofr_rej_src;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    irq_presenter i_irq_presenter (
        .clk(clk), .rst(rst),
        .offer_valid(offer_valid), .offer_src(offer_src), .offer_pri(offer_pri),
        .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
        .eoi_src_active(eoi_src_active),
        .irq_out(irq_out), .acc_valid(acc_valid), .acc_word(acc_word),
        .op_rej_valid(op_rej_valid), .op_rej_src(op_rej_src),
        .ofr_rej_valid(ofr_rej_valid), .ofr_rej_src(ofr_rej_src),
        .resend_req(resend_req)
    );

    // op: 0 accept, 1 threshold, 2 IPI priority, 3 EOI, 4 source offer (pri in 31:24, src in 23:0)
    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] data;
        logic        asrt;
        logic        irq;
        logic        opv;
        logic [23:0] ops;
        logic        ofv;
        logic [23:0] ofs;
        logic        rs;
        logic [31:0] acc;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{3'd4, 32'h05000010, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 24'h10, 1'b0, 32'h0, 8'd9},  // R9 refused below threshold 0
        '{3'd1, 32'h000000FF, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1, 32'h0, 8'd7},  // R7 lower, resend
        '{3'd4, 32'h05000010, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd9},  // R9 taken into empty slot
        '{3'd4, 32'h03000020, 1'b0, 1'b1, 1'b0, 24'h0,  1'b1, 24'h10, 1'b0, 32'h0, 8'd9},  // R9 displaces 0x10
        '{3'd4, 32'h04000030, 1'b0, 1'b1, 1'b0, 24'h0,  1'b1, 24'h30, 1'b0, 32'h0, 8'd9},  // R9 less urgent refused
        '{3'd0, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'hFF000020, 8'd3}, // R3
        '{3'd0, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h03000000, 8'd3}, // R3 empty
        '{3'd2, 32'h00000001, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd4},  // R4 IPI into slot
        '{3'd1, 32'h00000001, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd6},  // R6 raise, IPI reject hidden
        '{3'd1, 32'h00000001, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd6},  // R6 equal, no resend
        '{3'd3, 32'h06000040, 1'b1, 1'b1, 1'b1, 24'h40, 1'b0, 24'h0,  1'b1, 32'h0, 8'd8},  // R8 asserted source
        '{3'd0, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h06000002, 8'd3}, // R3 IPI accepted
        '{3'd3, 32'hFF000002, 1'b1, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd8},  // R8 IPI has no reject
        '{3'd2, 32'h000000FE, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd4},  // R4 no reject
        '{3'd4, 32'h10000050, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd11}, // R11 displaced IPI hidden
        '{3'd2, 32'h00000010, 1'b0, 1'b1, 1'b1, 24'h50, 1'b0, 24'h0,  1'b0, 32'h0, 8'd4},  // R4 equal priority rejects
        '{3'd0, 32'h0,        1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'hFF000002, 8'd3}, // R3
        '{3'd4, 32'h20000060, 1'b0, 1'b0, 1'b0, 24'h0,  1'b1, 24'h60, 1'b0, 32'h0, 8'd9},  // R9 refused, flag set
        '{3'd2, 32'h00000030, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b1, 32'h0, 8'd5},  // R5 resend
        '{3'd3, 32'h10000070, 1'b0, 1'b0, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd8},  // R8 not asserted
        '{3'd1, 32'h00000040, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd7},  // R7 IPI enters
        '{3'd4, 32'h08000080, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd9},  // R9
        '{3'd1, 32'h00000020, 1'b0, 1'b1, 1'b0, 24'h0,  1'b0, 24'h0,  1'b0, 32'h0, 8'd6},  // R6 raise, kept
        '{3'd1, 32'h00000008, 1'b0, 1'b0, 1'b1, 24'h80, 1'b0, 24'h0,  1'b0, 32'h0, 8'd6}   // R6 raise, rejects
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [31:0] data, input logic asrt);
        @(negedge clk);
        eoi_src_active = asrt;
        if (op == 3'd4) begin
            offer_valid = 1'b1;
            offer_pri   = data[31:24];
            offer_src   = data[23:0];
        end else begin
            op_valid = 1'b1;
            op_code  = op[1:0];
            op_data  = data;
        end
        @(negedge clk);
        op_valid = 1'b0; offer_valid = 1'b0; eoi_src_active = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string rq;
        do_reset();
        // R1 reset state
        @(negedge clk);
        chk("R1", "irq after reset", {31'd0, irq_out}, 32'd0);
        chk("R1", "no pulses after reset", {28'd0, op_rej_valid, ofr_rej_valid, resend_req, acc_valid}, 32'd0);
        drive(3'd0, 32'h0, 1'b0);
        chk("R1", "accept word after reset", acc_word, 32'h00000000);

        for (int i = 0; i < NV; i++) begin
            rq = $sformatf("R%0d", VECS[i].req);
            drive(VECS[i].op, VECS[i].data, VECS[i].asrt);
            chk(rq, $sformatf("v%0d irq", i), {31'd0, irq_out}, {31'd0, VECS[i].irq});   // R2
            chk(rq, $sformatf("v%0d op_rej", i), {7'd0, op_rej_valid, op_rej_src}, {7'd0, VECS[i].opv, VECS[i].ops});
            chk(rq, $sformatf("v%0d ofr_rej", i), {7'd0, ofr_rej_valid, ofr_rej_src}, {7'd0, VECS[i].ofv, VECS[i].ofs});
            chk(rq, $sformatf("v%0d resend", i), {31'd0, resend_req}, {31'd0, VECS[i].rs});
            if (VECS[i].op == 3'd0) begin
                chk(rq, $sformatf("v%0d acc_valid", i), {31'd0, acc_valid}, 32'd1);
                chk(rq, $sformatf("v%0d acc_word", i), acc_word, VECS[i].acc);
            end else begin
                chk(rq, $sformatf("v%0d acc idle", i), {31'd0, acc_valid}, 32'd0);
            end
        end

        // R10 offer colliding with an accept is returned, accept still proceeds
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'd0; op_data = '0;
        offer_valid = 1'b1; offer_src = 24'h90; offer_pri = 8'h00;
        @(negedge clk);
        op_valid = 1'b0; offer_valid = 1'b0;
        chk("R10", "collision accept word", acc_word, 32'h08000000);
        chk("R10", "collision offer returned", {7'd0, ofr_rej_valid, ofr_rej_src}, {8'h01, 24'h90});
        chk("R10", "collision irq", {31'd0, irq_out}, 32'd0);
        // R11 pulses last one cycle
        @(negedge clk);
        chk("R11", "reject pulse cleared", {30'd0, ofr_rej_valid, acc_valid}, 32'd0);
        // R10 collision set the need-resend flag; R7 lowering emits it
        drive(3'd1, 32'h000000FF, 1'b0);
        chk("R10", "resend after collision", {31'd0, resend_req}, 32'd1);
        chk("R7", "IPI enters on lowering", {31'd0, irq_out}, 32'd1);

        // R1 reset mid-run restores the registers
        do_reset();
        @(negedge clk);
        chk("R1", "irq after second reset", {31'd0, irq_out}, 32'd0);
        drive(3'd1, 32'h000000FF, 1'b0);
        chk("R1", "IPI priority reset to FF", {31'd0, irq_out}, 32'd0);
        chk("R1", "need flag reset", {31'd0, resend_req}, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule